// File: doc/BRIEF.md
# Multi-Rate Digital IF Downconverter

This block sits right after an 8-bit converter that samples, at a fixed 40 MHz, a real IF signal already limited to a 10 MHz band by an analog filter. It shifts that signal to complex baseband with a quarter-rate quadrature mixer that needs no multiplier. Each branch multiplies the input by a repeating pattern of zeros and plus or minus one. The block then runs zero, one or two cascaded stages, each a 15-tap lowpass FIR followed by decimation by 4. With no stage the channel is 10 MHz wide, with one it is 2.5 MHz and with two it is 625 kHz.

Each decimation stage trades sample rate for word length. The usable precision of the outputs rises from 9 bits with no filtering to 10 and then 11 bits. Results are always delivered as 12-bit two's-complement I and Q words, qualified by a one-cycle valid strobe. A two-bit mode input selects the bandwidth. Any change of that input restarts the whole datapath from an empty state.

Top module: `ifr_frontend`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_i` and `out_q` are all zero.
- R2: Accepted samples are numbered n = 0, 1, 2, ... from reset or from the last restart. The mixer gives I = 0, +x, 0, −x and Q = +x, 0, −x, 0 for n mod 4 = 0, 1, 2, 3. In mode 0 each accepted sample yields one output pair, sign-extended to 12 bits, so one of I or Q is always zero.
- R3: Each stage filter uses the symmetric taps −1, −1, 0, 2, 4, 7, 10, 22, 10, 7, 4, 2, 0, −1, −1 over the current input and the 14 before it. The sum is rounded by adding 16 and shifting right arithmetically by 5. The result is then saturated to a signed width of 10 bits for the first stage and 11 bits for the second.
- R4: In mode 1 a single stage runs on the mixer output. It produces a result for stage-input index k when k mod 4 = 3 and k ≥ 15.
- R5: Modes 2 and 3 both select 625 kHz. A second stage, using the same index rule, runs on the results of the first.
- R6: Every valid output lies in the signed range of 9, 10 or 11 bits for a cascade depth of 0, 1 or 2.
- R7: The mode register starts at 0 on reset. In any cycle where `mode` differs from it, the sample is discarded, every delay line and counter is cleared, pending results are dropped and `out_valid` is low in the next cycle. Numbering then restarts at 0.
- R8: Once running, consecutive valid strobes are spaced 1, 4 or 16 cycles apart for a depth of 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bandwidth select: 0 = 10 MHz, 1 = 2.5 MHz, 2 or 3 = 625 kHz |
| adc_in | input | 8 | Signed converter sample, one per cycle |
| out_valid | output | 1 | One-cycle strobe qualifying the output pair |
| out_i | output | 12 | In-phase baseband word, two's complement |
| out_q | output | 12 | Quadrature baseband word, two's complement |

## Verification
The embedded properties check, on every cycle, the strobe spacing for the selected depth, the precision limit of each depth, the zero on alternate branches at full rate, the quiet cycle after a restart, and that each stage fires only right after an accepted input with a full window. Only the bench scenarios can show that the numeric values are right. These are the mixer signs, the filter sums with their rounding, the exact sample on which each decimator fires, and the refill delay after a mode change. The bench compares every output word with an arithmetic model across several signal shapes in every mode and across chains of mode changes.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int TAPS       = 15;
  localparam int CENTER     = (TAPS - 1) / 2;
  localparam int COEF_W     = 8;
  localparam int COEF_SHIFT = 5;
  localparam int DEC        = 4;

  // symmetric lowpass taps, DC sum 64 (gain of two after the shift)
  function automatic logic signed [COEF_W-1:0] tap_coef(input int k);
    int m;
    m = (k > CENTER) ? (TAPS - 1 - k) : k;
    case (m)
      0, 1:    return -8'sd1;
      2:       return 8'sd0;
      3:       return 8'sd2;
      4:       return 8'sd4;
      5:       return 8'sd7;
      6:       return 8'sd10;
      default: return 8'sd22;
    endcase
  endfunction

  // cascade depth chosen by a mode value, limited to the stages built
  function automatic int stage_depth(input int m, input int n_stg);
    return (m < n_stg) ? m : n_stg;
  endfunction
endpackage

// File: rtl/ifr_mixer_fs4.sv
module ifr_mixer_fs4 #(
  parameter int ADC_W = 8
) (
  input  logic [1:0]                 ph,
  input  logic signed [ADC_W-1:0]    x,
  output logic signed [ADC_W:0]      mi,
  output logic signed [ADC_W:0]      mq
);
  localparam int MIX_W = ADC_W + 1;

  logic signed [MIX_W-1:0] xe, xn;

  always_comb begin
    xe = MIX_W'(x);
    xn = -xe;
    case (ph)
      2'd0: begin mi = '0; mq = xe; end
      2'd1: begin mi = xe; mq = '0; end
      2'd2: begin mi = '0; mq = xn; end
      default: begin mi = xn; mq = '0; end
    endcase
  end
endmodule

// File: rtl/ifr_fir_dec4.sv
module ifr_fir_dec4
  import ifr_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int OUT_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_v,
  input  logic signed [IN_W-1:0]   in_i,
  input  logic signed [IN_W-1:0]   in_q,
  output logic                     out_v,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  localparam int ACC_W  = IN_W + COEF_W;
  localparam int FILL_W = $clog2(TAPS + 1);
  localparam int FULL   = TAPS - 1;
  localparam logic signed [ACC_W-1:0] HI   = ACC_W'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO   = -HI - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 <<< (COEF_SHIFT - 1));

  logic signed [IN_W-1:0]  dl_i [0:TAPS-2];
  logic signed [IN_W-1:0]  dl_q [0:TAPS-2];
  logic [1:0]              dph;
  logic [FILL_W-1:0]       fill;
  logic signed [ACC_W-1:0] acc_i, acc_q;
  logic                    fire;

  function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + HALF) >>> COEF_SHIFT;
    if (r > HI)      return OUT_W'(HI);
    else if (r < LO) return OUT_W'(LO);
    else             return OUT_W'(r);
  endfunction

  always_comb begin
    acc_i = ACC_W'(in_i) * ACC_W'(tap_coef(0));
    acc_q = ACC_W'(in_q) * ACC_W'(tap_coef(0));
    for (int k = 1; k < TAPS; k++) begin
      acc_i += ACC_W'(dl_i[k-1]) * ACC_W'(tap_coef(k));
      acc_q += ACC_W'(dl_q[k-1]) * ACC_W'(tap_coef(k));
    end
  end

  assign fire = in_v && (dph == 2'(DEC - 1)) && (fill >= FILL_W'(FULL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS - 1; k++) begin
        dl_i[k] <= '0;
        dl_q[k] <= '0;
      end
      dph   <= '0;
      fill  <= '0;
      out_v <= 1'b0;
      out_i <= '0;
      out_q <= '0;
    end else if (clr) begin
      for (int k = 0; k < TAPS - 1; k++) begin
        dl_i[k] <= '0;
        dl_q[k] <= '0;
      end
      dph   <= '0;
      fill  <= '0;
      out_v <= 1'b0;
    end else begin
      out_v <= fire;
      if (in_v) begin
        dl_i[0] <= in_i;
        dl_q[0] <= in_q;
        for (int k = 1; k < TAPS - 1; k++) begin
          dl_i[k] <= dl_i[k-1];
          dl_q[k] <= dl_q[k-1];
        end
        dph <= dph + 2'd1;
        if (fill != FILL_W'(TAPS)) fill <= fill + FILL_W'(1);
      end
      if (fire) begin
        out_i <= rnd_sat(acc_i);
        out_q <= rnd_sat(acc_q);
      end
    end
  end

  AST_FIR_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> $past(in_v)); // R4
  AST_FIR_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> (fill == FILL_W'(TAPS))); // R3
endmodule

// File: rtl/ifr_frontend.sv
module ifr_frontend
  import ifr_pkg::*;
#(
  parameter int ADC_W  = 8,
  parameter int OUT_W  = 12,
  parameter int N_STG  = 2,
  parameter int MODE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MODE_W-1:0]        mode,
  input  logic signed [ADC_W-1:0]  adc_in,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  localparam int MIX_W = ADC_W + 1;
  localparam int DEP_W = $clog2(N_STG + 1);
  localparam int GAP_W = 2 * N_STG + 2;

  logic [MODE_W-1:0]      mode_q;
  logic                   flush;
  logic [1:0]             mix_ph;
  logic [DEP_W-1:0]       dep;
  logic signed [MIX_W-1:0] mix_i, mix_q;

  logic signed [OUT_W-1:0] sb_i [0:N_STG];
  logic signed [OUT_W-1:0] sb_q [0:N_STG];
  logic                    sv   [0:N_STG];

  assign flush = (mode != mode_q);
  assign dep   = DEP_W'(stage_depth(int'(mode_q), N_STG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mix_ph <= '0;
    end else begin
      mode_q <= mode;
      mix_ph <= flush ? 2'd0 : mix_ph + 2'd1;
    end
  end

  ifr_mixer_fs4 #(.ADC_W(ADC_W)) u_mix (
    .ph (mix_ph),
    .x  (adc_in),
    .mi (mix_i),
    .mq (mix_q)
  );

  assign sb_i[0] = OUT_W'(mix_i);
  assign sb_q[0] = OUT_W'(mix_q);
  assign sv[0]   = !flush;

  for (genvar g = 0; g < N_STG; g++) begin : g_stage
    logic                        fo_v;
    logic signed [MIX_W+g:0]     fo_i, fo_q;
    ifr_fir_dec4 #(.IN_W(MIX_W + g), .OUT_W(MIX_W + g + 1)) u_fir (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .in_v  (sv[g]),
      .in_i  (sb_i[g][MIX_W+g-1:0]),
      .in_q  (sb_q[g][MIX_W+g-1:0]),
      .out_v (fo_v),
      .out_i (fo_i),
      .out_q (fo_q)
    );
    assign sb_i[g+1] = OUT_W'(fo_i);
    assign sb_q[g+1] = OUT_W'(fo_q);
    assign sv[g+1]   = fo_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= !flush && sv[dep];
      if (!flush && sv[dep]) begin
        out_i <= sb_i[dep];
        out_q <= sb_q[dep];
      end
    end
  end

  // observation logic for the properties below
  logic [GAP_W-1:0] gap;
  logic             have_prev;
  logic [GAP_W-1:0] spacing;
  int               lim;
  logic             out_fits;

  assign spacing  = GAP_W'(1) << (2 * int'(dep));
  assign lim      = 1 << (MIX_W - 1 + int'(dep));
  assign out_fits = (int'(out_i) >= -lim) && (int'(out_i) < lim) &&
                    (int'(out_q) >= -lim) && (int'(out_q) < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      have_prev <= 1'b0;
    end else if (flush) begin
      gap       <= '0;
      have_prev <= 1'b0;
    end else if (out_valid) begin
      gap       <= GAP_W'(1);
      have_prev <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + GAP_W'(1);
    end
  end

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R7
  AST_RES_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fits); // R6
  AST_IQ_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dep == '0) |-> (out_i == '0 || out_q == '0)); // R2
  AST_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev) |-> (gap == spacing)); // R8
endmodule

// File: tb/tb_ifr_frontend.sv
module tb_ifr_frontend;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic signed [7:0] adc_in = '0;
  logic              out_valid;
  logic signed [11:0] out_i, out_q;

  always #5 clk = ~clk;

  ifr_frontend dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .adc_in(adc_in),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  int cf [15] = '{-1, -1, 0, 2, 4, 7, 10, 22, 10, 7, 4, 2, 0, -1, -1};
  int wi [2][15];
  int wq [2][15];
  int ns [2];
  int n0;
  int mq_model;
  int exp_i [$];
  int exp_q [$];
  int bgap;
  bit bprev;
  bit just_flushed;
  int got;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int depth_of(input int m);
    return (m > 2) ? 2 : m;
  endfunction

  function automatic string tag_of(input int m);
    int d;
    d = depth_of(m);
    return (d == 0) ? "R2" : (d == 1) ? "R3 R4" : "R3 R5";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      ns[s] = 0;
      for (int k = 0; k < 15; k++) begin wi[s][k] = 0; wq[s][k] = 0; end
    end
    n0 = 0;
    exp_i.delete();
    exp_q.delete();
    bprev = 0;
    bgap = 0;
  endtask

  // R3: tap sum, +16, arithmetic shift by 5, clamp to the stage width
  function automatic int filt(input int s, input bit use_q);
    int acc, r, hi;
    acc = 0;
    for (int k = 0; k < 15; k++) acc += cf[k] * (use_q ? wq[s][k] : wi[s][k]);
    r = (acc + 16) >>> 5;
    hi = (1 << (9 + s)) - 1;
    if (r > hi) r = hi;
    if (r < -hi - 1) r = -hi - 1;
    return r;
  endfunction

  task automatic stage_push(input int s, input int xi, input int xq,
                            output bit fired, output int yi, output int yq);
    for (int k = 14; k > 0; k--) begin
      wi[s][k] = wi[s][k-1];
      wq[s][k] = wq[s][k-1];
    end
    wi[s][0] = xi;
    wq[s][0] = xq;
    fired = (ns[s] % 4 == 3) && (ns[s] >= 14);
    ns[s]++;
    yi = filt(s, 0);
    yq = filt(s, 1);
  endtask

  task automatic model_step(input int x, input int m);
    int vi, vq, p, y1i, y1q, y2i, y2q;
    bit f1, f2;
    if (m != mq_model) begin
      mq_model = m;
      model_clear();
      just_flushed = 1;
      return;
    end
    p = n0 % 4;
    n0++;
    vi = (p == 1) ? x : (p == 3) ? -x : 0;
    vq = (p == 0) ? x : (p == 2) ? -x : 0;
    if (depth_of(m) == 0) begin
      exp_i.push_back(vi); exp_q.push_back(vq);
    end else begin
      stage_push(0, vi, vq, f1, y1i, y1q);
      if (f1) begin
        if (depth_of(m) == 1) begin
          exp_i.push_back(y1i); exp_q.push_back(y1q);
        end else begin
          stage_push(1, y1i, y1q, f2, y2i, y2q);
          if (f2) begin exp_i.push_back(y2i); exp_q.push_back(y2q); end
        end
      end
    end
  endtask

  task automatic monitor();
    int ei, eq, lim, ai, aq, d;
    d = depth_of(int'(mode));
    ai = int'(out_i);
    aq = int'(out_q);
    if (just_flushed) begin
      check(out_valid == 1'b0, "R7 quiet after restart", int'(out_valid), 0);
      just_flushed = 0;
    end
    if (out_valid) begin
      got++;
      if (exp_i.size() == 0) begin
        check(1'b0, "R7 unexpected strobe during refill", 1, 0);
      end else begin
        ei = exp_i.pop_front();
        eq = exp_q.pop_front();
        check(ai == ei, {tag_of(int'(mode)), " I word"}, ai, ei);
        check(aq == eq, {tag_of(int'(mode)), " Q word"}, aq, eq);
      end
      lim = 1 << (8 + d);
      check(ai >= -lim && ai < lim && aq >= -lim && aq < lim, "R6 precision", ai, lim);
      if (bprev) check(bgap == (1 << (2 * d)), "R8 strobe spacing", bgap, 1 << (2 * d));
      bprev = 1;
      bgap = 1;
    end else begin
      bgap++;
    end
  endtask

  function automatic int pat_x(input int pat, input int c);
    case (pat)
      0: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr[7:0]));
      end
      1: return (c % 4 == 0) ? 127 : (c % 4 == 2) ? -128 : 0;
      2: return -128;
      3: return (c % 2 == 1) ? -128 : 127;
      default: return ((c * 7) % 256) - 128;
    endcase
  endfunction

  task automatic do_reset(input int m);
    rst_n = 1'b0;
    mode = 2'(m);
    adc_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_i == '0 && out_q == '0, "R1 reset state",
          int'(out_valid) + int'(out_i) + int'(out_q), 0);
    mq_model = 0;
    just_flushed = 0;
    model_clear();
  endtask

  task automatic seg(input int m, input int pat, input int n);
    for (int c = 0; c < n; c++) begin
      monitor();
      if (c == 0 && rst_n == 1'b0) begin
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 first cycle after reset", int'(out_valid), 0);
      end
      mode = 2'(m);
      adc_in = 8'(pat_x(pat, c));
      model_step(int'(adc_in), m);
      @(negedge clk);
    end
  endtask

  task automatic end_run(input int m);
    monitor();
    check(got > 0, {tag_of(m), " outputs produced"}, got, 1);
    check(exp_i.size() <= 1, {tag_of(m), " no missing outputs"}, exp_i.size(), 1);
  endtask

  initial begin
    int len;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int pat = 0; pat < 5; pat++) begin
        got = 0;
        len = (m == 0) ? 60 : (m == 1) ? 200 : 700;
        do_reset(m);
        seg(m, pat, len);
        end_run(m);
      end
    end
    // restart chain: every mode change flushes and refills (R7)
    got = 0;
    do_reset(2);
    seg(2, 0, 300);
    seg(1, 0, 200);
    seg(0, 4, 40);
    seg(3, 1, 300);
    seg(2, 0, 300);
    seg(1, 3, 120);
    end_run(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule